// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block sets the instruction-cycle rhythm of a small 8-bit microcontroller core. It splits the oscillator into cycles of four phases and drives one strobe per phase. On the last phase of every cycle it asks for the next program word and captures it into a single-word prefetch register. It then decides what the execute stage does in the next cycle. That can be the prefetched instruction, the second half of a two-word instruction, or an inserted NOP.

The execute stage sends two flags. One says that the executing word opens a two-word instruction. The other says that its conditional test passed or that it moved the program counter. When an instruction redirects the program counter, the sequencer discards the prefetched word and runs a NOP in its place. A taken single-word instruction therefore takes two cycles, and a taken two-word branch takes three. Some words have their upper prefix bits all set but do not follow an opening word; they run as NOPs. The block does no opcode decoding beyond this prefix test.

Top module: `insn_cycle_seq`

## Requirements
- R1: `phase_o` is one-hot and rotates from bit 0 to bit 3 with one step per clock, so every instruction cycle lasts exactly four clocks.
- R2: `fetch_adv_o` is high only during phase bit 3. The word on `fetch_word_i` at the clock edge that ends this phase is captured as the prefetched word.
- R3: `exec_en_o` is high only during phase bit 0, and only when the current cycle is not a NOP (`nop_o` low).
- R4: Without redirects, each word executes for one cycle on `exec_word_o`. A word captured at the end of cycle n executes in cycle n+2.
- R5: If `taken_i` is high at the end of an active single-word cycle, the next cycle is an injected NOP (`exec_word_o` = 16'h0000, `nop_o` high). The prefetched word is dropped, and the word captured at that same edge executes in the cycle after the NOP.
- R6: If `two_word_i` is high at the end of an active non-continuation cycle, the next cycle runs the prefetched word as the continuation. In that cycle `nop_o` is low whatever the word's upper four bits are, and `taken_i` in the opening cycle has no effect.
- R7: `taken_i` high at the end of a continuation cycle injects a NOP and drops the prefetched word, so a taken two-word branch uses three cycles.
- R8: A word whose bits [15:12] are all 1 and that is not a continuation runs as a NOP: `nop_o` is high and `exec_en_o` stays low.
- R9: At the end of any NOP cycle (injected or stray), `taken_i` and `two_word_i` are ignored, and the prefetched word executes next as an ordinary instruction.
- R10: Synchronous active-high `rst_i` places the sequencer at phase bit 0 with a NOP executing and a NOP in the prefetch register, so the first two cycles after reset are NOPs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fetch_word_i | input | 16 | Program word returned for the current fetch |
| two_word_i | input | 1 | Executing word opens a two-word instruction |
| taken_i | input | 1 | Executing instruction passed its test or changed the program counter |
| phase_o | output | 4 | One-hot phase strobes |
| fetch_adv_o | output | 1 | Request for the next program word (last phase) |
| exec_en_o | output | 1 | Execute-enable on the first phase of a non-NOP cycle |
| nop_o | output | 1 | Current cycle is a NOP (injected or stray) |
| exec_word_o | output | 16 | Word executing in the current cycle |

## Verification
The bench uses the default parameters: a 16-bit word, four phases, a 4-bit continuation prefix and 16'h0000 as the NOP word. With a 4-bit prefix, continuation-looking words such as 16'hF111 are easy to place. The bench puts them in every role: a legitimate second word, a stray after a NOP, and a stray reached after a redirect. A flag wrongly honoured in a NOP or continuation cycle then shows up directly as a changed `nop_o` or `exec_word_o`. Four phases keep a full cycle at four clocks, so every boundary edge of a 14-cycle program is checked phase by phase.

// File: rtl/icseq_pkg.sv
package icseq_pkg;

    // What occupies the execute slot during the current instruction cycle.
    typedef enum logic [1:0] {
        SLOT_RUN    = 2'd0,  // ordinary word (may still turn out to be a stray)
        SLOT_CONT   = 2'd1,  // second word of a two-word instruction
        SLOT_BUBBLE = 2'd2   // injected or reset NOP
    } slot_e;

endpackage

// File: rtl/icseq_phase.sv
module icseq_phase #(
    parameter int PHASES = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [PHASES-1:0] phase_o,
    output logic              last_o
);

    localparam int CNT_W = (PHASES > 1) ? $clog2(PHASES) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (last_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_o = (st_q.cnt == CNT_W'(PHASES - 1));

    for (genvar g = 0; g < PHASES; g++) begin : g_strobe
        assign phase_o[g] = (st_q.cnt == CNT_W'(g));
    end

endmodule

// File: rtl/icseq_ctrl.sv
module icseq_ctrl
    import icseq_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter int                PFX_W    = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              adv_i,
    input  logic [WORD_W-1:0] fetch_word_i,
    input  logic              two_word_i,
    input  logic              taken_i,
    output logic [WORD_W-1:0] exec_word_o,
    output logic              nop_o,
    output logic              cont_o
);

    localparam logic [PFX_W-1:0] PFX_ONES = '1;

    typedef struct packed {
        logic [WORD_W-1:0] cur_word;
        slot_e             cur_slot;
        logic [WORD_W-1:0] pref_word;
        logic              pref_bubble;
    } seq_t;

    seq_t st_d, st_q;

    logic stray;
    logic active;
    logic opens_pair;
    logic flush;

    always_comb begin
        stray      = (st_q.cur_slot == SLOT_RUN) &&
                     (st_q.cur_word[WORD_W-1 -: PFX_W] == PFX_ONES);
        active     = ((st_q.cur_slot == SLOT_RUN) && !stray) ||
                     (st_q.cur_slot == SLOT_CONT);
        opens_pair = (st_q.cur_slot == SLOT_RUN) && !stray && two_word_i;
        flush      = active && taken_i && !opens_pair;

        st_d = st_q;
        if (adv_i) begin
            st_d.pref_word   = fetch_word_i;
            st_d.pref_bubble = 1'b0;
            if (flush) begin
                st_d.cur_word = NOP_WORD;
                st_d.cur_slot = SLOT_BUBBLE;
            end else if (st_q.pref_bubble) begin
                st_d.cur_word = NOP_WORD;
                st_d.cur_slot = SLOT_BUBBLE;
            end else begin
                st_d.cur_word = st_q.pref_word;
                st_d.cur_slot = opens_pair ? SLOT_CONT : SLOT_RUN;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cur_word    <= NOP_WORD;
            st_q.cur_slot    <= SLOT_BUBBLE;
            st_q.pref_word   <= NOP_WORD;
            st_q.pref_bubble <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign exec_word_o = st_q.cur_word;
    assign nop_o       = (st_q.cur_slot == SLOT_BUBBLE) || stray;
    assign cont_o      = (st_q.cur_slot == SLOT_CONT);

endmodule

// File: rtl/insn_cycle_seq.sv
module insn_cycle_seq #(
    parameter int                WORD_W   = 16,
    parameter int                PHASES   = 4,
    parameter int                PFX_W    = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] fetch_word_i,
    input  logic              two_word_i,
    input  logic              taken_i,
    output logic [PHASES-1:0] phase_o,
    output logic              fetch_adv_o,
    output logic              exec_en_o,
    output logic              nop_o,
    output logic [WORD_W-1:0] exec_word_o
);

    logic last_w;
    logic cont_w;

    icseq_phase #(
        .PHASES(PHASES)
    ) u_phase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .phase_o(phase_o),
        .last_o (last_w)
    );

    icseq_ctrl #(
        .WORD_W  (WORD_W),
        .PFX_W   (PFX_W),
        .NOP_WORD(NOP_WORD)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .adv_i       (last_w),
        .fetch_word_i(fetch_word_i),
        .two_word_i  (two_word_i),
        .taken_i     (taken_i),
        .exec_word_o (exec_word_o),
        .nop_o       (nop_o),
        .cont_o      (cont_w)
    );

    assign fetch_adv_o = last_w;
    assign exec_en_o   = phase_o[0] && !nop_o;

endmodule

// File: rtl/insn_cycle_seq_chk.sv
module insn_cycle_seq_chk #(
    parameter int                WORD_W   = 16,
    parameter int                PHASES   = 4,
    parameter int                PFX_W    = 4,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              two_word_i,
    input logic              taken_i,
    input logic [PHASES-1:0] phase_o,
    input logic              fetch_adv_o,
    input logic              exec_en_o,
    input logic              nop_o,
    input logic [WORD_W-1:0] exec_word_o,
    input logic              cont_i
);

    localparam logic [PFX_W-1:0] PFX_ONES = '1;

    // R1: one strobe at a time, stepping forward each clock
    p_onehot_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(phase_o) == 1);
    p_rotate_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_o[0] |=> phase_o[1]);

    // R2: fetch request sits on the last phase and is followed by a new cycle
    p_fadv_last_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_adv_o |-> phase_o[PHASES-1]);
    p_fadv_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_adv_o |=> phase_o[0]);

    // R3: execute-enable only on the first phase of a real instruction
    p_exec_en_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        exec_en_o |-> (phase_o[0] && !nop_o));

    // R4: the executing word only changes at a cycle boundary
    p_word_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !fetch_adv_o |=> ($stable(exec_word_o) && $stable(nop_o)));

    // R5, R7: a taken redirect from an active cycle injects a NOP
    p_flush_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_adv_o && taken_i && !nop_o && (cont_i || !two_word_i))
        |=> (nop_o && exec_word_o == NOP_WORD));

    // R6: an opening word is followed by a continuation cycle
    p_pair_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_adv_o && !nop_o && !cont_i && two_word_i)
        |=> (cont_i && !nop_o));

    // R8: a prefixed word outside a pair is a NOP
    p_stray_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (exec_word_o[WORD_W-1 -: PFX_W] == PFX_ONES && !cont_i) |-> nop_o);

    // R9: flags during a NOP cycle never open a pair
    p_nop_ignores_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_adv_o && nop_o) |=> !cont_i);

    // R10: reset lands on the first phase with a NOP executing
    p_reset_r10: assert property (@(posedge clk_i)
        rst_i |=> (phase_o[0] && nop_o && exec_word_o == NOP_WORD));

endmodule

bind insn_cycle_seq insn_cycle_seq_chk #(
    .WORD_W  (WORD_W),
    .PHASES  (PHASES),
    .PFX_W   (PFX_W),
    .NOP_WORD(NOP_WORD)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .two_word_i (two_word_i),
    .taken_i    (taken_i),
    .phase_o    (phase_o),
    .fetch_adv_o(fetch_adv_o),
    .exec_en_o  (exec_en_o),
    .nop_o      (nop_o),
    .exec_word_o(exec_word_o),
    .cont_i     (cont_w)
);

// File: tb/insn_cycle_seq_bench.sv
module insn_cycle_seq_bench;

    logic        clk;
    logic        rst;
    logic [15:0] fetch_word;
    logic        two_word;
    logic        taken;
    logic [3:0]  phase;
    logic        fetch_adv;
    logic        exec_en;
    logic        nop;
    logic [15:0] exec_word;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    insn_cycle_seq u_insn_cycle_seq (
        .clk_i       (clk),
        .rst_i       (rst),
        .fetch_word_i(fetch_word),
        .two_word_i  (two_word),
        .taken_i     (taken),
        .phase_o     (phase),
        .fetch_adv_o (fetch_adv),
        .exec_en_o   (exec_en),
        .nop_o       (nop),
        .exec_word_o (exec_word)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // {fetch word, two_word, taken, expected nop, expected executing word}
    // Each row is one instruction cycle, observed on its first phase.
    localparam int NV = 14;
    localparam logic [34:0] VECS [NV] = '{
        {16'h1234, 1'b0, 1'b0, 1'b1, 16'h0000},
        {16'h2345, 1'b0, 1'b0, 1'b1, 16'h0000},
        {16'h3456, 1'b0, 1'b1, 1'b0, 16'h1234},
        {16'hF111, 1'b0, 1'b1, 1'b1, 16'h0000},
        {16'hF444, 1'b1, 1'b1, 1'b0, 16'h3456},
        {16'h6666, 1'b1, 1'b0, 1'b0, 16'hF111},
        {16'hF777, 1'b1, 1'b1, 1'b1, 16'hF444},
        {16'h8888, 1'b1, 1'b0, 1'b0, 16'h6666},
        {16'h1111, 1'b0, 1'b1, 1'b0, 16'hF777},
        {16'hF222, 1'b0, 1'b0, 1'b1, 16'h0000},
        {16'h2222, 1'b0, 1'b0, 1'b0, 16'h1111},
        {16'h3333, 1'b0, 1'b0, 1'b1, 16'hF222},
        {16'h0000, 1'b0, 1'b0, 1'b0, 16'h2222},
        {16'h0000, 1'b0, 1'b0, 1'b0, 16'h3333}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:      return "R10";
            3:         return "R5";
            4, 7:      return "R9";
            5, 8:      return "R6";
            6, 11:     return "R8";
            9, 10:     return "R7";
            default:   return "R4";
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input string tag, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        fetch_word = 16'h0000;
        two_word   = 1'b0;
        taken      = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Table walk: one row per instruction cycle.
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VECS[i];
            chk(16'(phase), 16'h0001, "R1", "phase at cycle start");
            chk(16'(nop), 16'(v[16]), vec_tag(i), "nop");
            chk(exec_word, v[15:0], vec_tag(i), "executing word");
            chk(16'(exec_en), 16'(!v[16]), "R3", "execute-enable");
            chk(16'(fetch_adv), 16'h0000, "R2", "fetch advance off phase");
            fetch_word = v[34:19];
            two_word   = v[18];
            taken      = v[17];
            for (int k = 1; k < 4; k++) begin
                @(negedge clk);
                chk(16'(phase), 16'(1 << k), "R1", "phase strobe");
                chk(16'(exec_en), 16'h0000, "R3", "execute-enable off phase");
                if (k == 3) chk(16'(fetch_adv), 16'h0001, "R2", "fetch advance");
            end
            @(negedge clk);
        end

        // Reset in the middle of a cycle.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(16'(phase), 16'h0001, "R10", "phase after reset");
        chk(16'(nop), 16'h0001, "R10", "nop after reset");
        chk(exec_word, 16'h0000, "R10", "word after reset");
        chk(16'(exec_en), 16'h0000, "R10", "execute-enable after reset");
        chk(16'(fetch_adv), 16'h0000, "R10", "fetch advance after reset");
        fetch_word = 16'h4444;
        two_word   = 1'b0;
        taken      = 1'b0;
        repeat (4) @(negedge clk);
        chk(16'(nop), 16'h0001, "R10", "second cycle after reset");
        chk(exec_word, 16'h0000, "R10", "prefetch holds NOP");
        fetch_word = 16'h5555;
        repeat (4) @(negedge clk);
        chk(exec_word, 16'h4444, "R4", "first fetched word runs");
        chk(16'(nop), 16'h0000, "R4", "first fetched word not NOP");
        chk(16'(exec_en), 16'h0001, "R3", "execute-enable on real word");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule